// File: doc/BRIEF.md
# Zoned Associative Address Translation Lookup

This block searches a fully associative table of translation entries for a virtual address. Each entry carries its own page size, an optional 8-bit owner tag that ties it to one process, a physical page number, write and execute permission bits and a 4-bit zone selector. A zone protection word, supplied from outside, gives every zone a 2-bit code. The code can hide the entry from user accesses, leave the entry's own permissions in force, or widen them for supervisor or for all accesses.

A lookup is issued with a virtual address, an access kind (read, write or fetch) and a user flag. One clock later the block returns miss, protection fault or hit. On a hit it also returns the index of the deciding entry, the translated physical address, the page-size code and the granted rights. The lowest-numbered matching entry decides the result, even when it faults. Entries are loaded through a plain write port. Refill policy and register access belong to the surrounding logic.

Top module: `tlb_zone_lookup`

## Requirements
- R1: Tag bits [9:7] hold a size code s (0..7) that selects a page of 1024·4^s bytes (1K, 4K, 16K, 64K, 256K, 1M, 4M, 16M). Address bits below 10+2s are offset bits and take no part in the match.
- R2: An entry matches only when tag bit [6] (valid) is 1 and tag bits [31:10] equal the virtual address bits [31:10] above the page offset.
- R3: An owner tag of zero matches any process. A nonzero owner tag matches only when it equals the 8-bit current process ID.
- R4: Data bits [7:4] hold the zone number z. Its 2-bit code is zone-word bits [31-2z : 30-2z], so zone 0 is bits [31:30] and zone 1 is bits [29:28].
- R5: Code 0 hides the entry from user lookups, and the search goes on. For supervisor lookups the entry keeps its own bits. Code 1 keeps the entry's write bit (data [8]) and execute bit (data [9]). Code 2 grants write and execute to supervisor lookups only. Code 3 grants both to every lookup.
- R6: Code 1 is used when zone support is off, and also when z is greater than the configured zone count.
- R7: Access kind is 0 read, 1 write, 2 fetch (3 is treated as read). A read never faults. A write without write right, or a fetch without execute right, gives status 1 (fault) with the index of the entry.
- R8: The lowest-indexed matching entry alone decides the result. With no match the status is 0 (miss). On miss and fault, the physical address, size and rights outputs are zero, and on miss the index is zero too.
- R9: On a hit (status 2) the physical address is data bits [31:10] above the page offset, joined with the virtual address offset bits. Rights are {read, write, execute} with read always 1. The size output repeats the entry's size code.
- R10: A response appears, flagged by rsp_valid, exactly one cycle after the request. rsp_valid is low in cycles that follow no request.
- R11: After reset every entry is invalid and rsp_valid is low.
- R12: An entry written through the write port takes effect for lookups issued from the next cycle on. Writing valid=0 removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDXW | Entry index to write |
| wr_tag | input | 26 | Tag word bits [31:6]: page number, size code, valid |
| wr_data | input | 28 | Data word bits [31:4]: physical page, execute, write, zone |
| wr_ptag | input | 8 | Owner process tag, 0 for global |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 for user privilege, 0 for supervisor |
| cur_pid | input | 8 | Current process ID |
| zone_word | input | 32 | Zone protection word, 2 bits per zone |
| zone_en | input | 1 | Zone support enabled |
| zone_count | input | 4 | Highest zone number in use |
| rsp_valid | output | 1 | Response valid |
| rsp_status | output | 2 | 0 miss, 1 fault, 2 hit |
| rsp_idx | output | IDXW | Deciding entry index |
| rsp_paddr | output | 32 | Physical address |
| rsp_size | output | 3 | Page size code of the hit entry |
| rsp_rights | output | 3 | Granted {read, write, execute} |

## Verification
Every lookup result is registered straight from the match and priority logic. A corrupted entry, a wrong zone-code extraction or a broken priority choice therefore shows up at the response ports in the cycle right after the affected request, as a wrong status, index, address or rights value. Stored state that goes bad (a lost valid bit, a wrong owner tag) stays hidden until a lookup reaches that entry. The stimulus therefore aims lookups at each entry under several zone settings, process IDs and privileges, and uses overlapping entries to expose ordering faults.

// File: rtl/tlb_zone_pkg.sv
package tlb_zone_pkg;

  typedef enum logic [1:0] {
    ST_MISS  = 2'd0,
    ST_FAULT = 2'd1,
    ST_HIT   = 2'd2
  } tlb_status_e;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam int PN_W = 22;  // page-number bits above the 1K floor

  typedef struct packed {
    logic [PN_W-1:0] vpn;
    logic [2:0]      size;
    logic            valid;
    logic [PN_W-1:0] rpn;
    logic            ex;
    logic            wr;
    logic [3:0]      zone;
    logic [7:0]      ptag;
  } tlb_entry_t;

  // Page-number bits that fall inside the page offset for a size code.
  function automatic logic [PN_W-1:0] pn_offset_mask(input logic [2:0] s);
    return (PN_W'(1) << {s, 1'b0}) - PN_W'(1);
  endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_zone_pkg::*;
#(
  parameter int N    = 64,
  parameter int IDXW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [31:6]      wr_tag,
  input  logic [31:4]      wr_data,
  input  logic [7:0]       wr_ptag,
  output tlb_entry_t       ent_q [N]
);

  tlb_entry_t ent_d [N];
  tlb_entry_t wr_ent;

  always_comb begin
    wr_ent.vpn   = wr_tag[31:10];
    wr_ent.size  = wr_tag[9:7];
    wr_ent.valid = wr_tag[6];
    wr_ent.rpn   = wr_data[31:10];
    wr_ent.ex    = wr_data[9];
    wr_ent.wr    = wr_data[8];
    wr_ent.zone  = wr_data[7:4];
    wr_ent.ptag  = wr_ptag;
  end

  always_comb begin
    ent_d = ent_q;
    if (wr_en) ent_d[wr_idx] = wr_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) ent_q[i] <= '0;
    end else if (wr_en) begin
      ent_q <= ent_d;
    end
  end

endmodule

// File: rtl/tlb_entry_eval.sv
module tlb_entry_eval
  import tlb_zone_pkg::*;
(
  input  tlb_entry_t       ent,
  input  logic [PN_W-1:0]  va_pn,
  input  logic             user,
  input  logic [7:0]       pid,
  input  logic [31:0]      zone_word,
  input  logic             zone_en,
  input  logic [3:0]       zone_count,
  output logic             claim,
  output logic             wr_ok,
  output logic             ex_ok
);

  logic [PN_W-1:0] cmp_mask;
  logic            addr_eq;
  logic            pid_ok;
  logic [1:0]      raw_code;
  logic [1:0]      code;

  always_comb begin
    cmp_mask = ~pn_offset_mask(ent.size);
    addr_eq  = ((va_pn ^ ent.vpn) & cmp_mask) == '0;
    pid_ok   = (ent.ptag == 8'd0) || (ent.ptag == pid);
  end

  always_comb begin
    raw_code = 2'd0;
    for (int z = 0; z < 16; z++) begin
      if (ent.zone == 4'(z)) raw_code = zone_word[31-2*z -: 2];
    end
    if (!zone_en || (ent.zone > zone_count)) code = 2'd1;
    else                                     code = raw_code;
  end

  always_comb begin
    claim = ent.valid && addr_eq && pid_ok && !((code == 2'd0) && user);
    wr_ok = ent.wr || (code == 2'd3) || ((code == 2'd2) && !user);
    ex_ok = ent.ex || (code == 2'd3) || ((code == 2'd2) && !user);
  end

endmodule

// File: rtl/tlb_prio_pick.sv
module tlb_prio_pick #(
  parameter int N    = 64,
  parameter int IDXW = 6
) (
  input  logic [N-1:0]    req,
  output logic            found,
  output logic [IDXW-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDXW'(i);
      end
    end
  end

endmodule

// File: rtl/tlb_zone_lookup.sv
module tlb_zone_lookup
  import tlb_zone_pkg::*;
#(
  parameter int N    = 64,
  parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [31:6]      wr_tag,
  input  logic [31:4]      wr_data,
  input  logic [7:0]       wr_ptag,
  input  logic             req_valid,
  input  logic [31:0]      req_vaddr,
  input  logic [1:0]       req_acc,
  input  logic             req_user,
  input  logic [7:0]       cur_pid,
  input  logic [31:0]      zone_word,
  input  logic             zone_en,
  input  logic [3:0]       zone_count,
  output logic             rsp_valid,
  output logic [1:0]       rsp_status,
  output logic [IDXW-1:0]  rsp_idx,
  output logic [31:0]      rsp_paddr,
  output logic [2:0]       rsp_size,
  output logic [2:0]       rsp_rights
);

  tlb_entry_t      ent [N];
  logic [N-1:0]    claim_v;
  logic [N-1:0]    wr_ok_v;
  logic [N-1:0]    ex_ok_v;
  logic            found;
  logic [IDXW-1:0] pick;

  tlb_entry_store #(.N(N), .IDXW(IDXW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_tag  (wr_tag),
    .wr_data (wr_data),
    .wr_ptag (wr_ptag),
    .ent_q   (ent)
  );

  for (genvar g = 0; g < N; g++) begin : g_eval
    tlb_entry_eval u_eval (
      .ent        (ent[g]),
      .va_pn      (req_vaddr[31:10]),
      .user       (req_user),
      .pid        (cur_pid),
      .zone_word  (zone_word),
      .zone_en    (zone_en),
      .zone_count (zone_count),
      .claim      (claim_v[g]),
      .wr_ok      (wr_ok_v[g]),
      .ex_ok      (ex_ok_v[g])
    );
  end

  tlb_prio_pick #(.N(N), .IDXW(IDXW)) u_pick (
    .req   (claim_v),
    .found (found),
    .idx   (pick)
  );

  // Next-state of the response.
  tlb_entry_t      win;
  logic            win_wr;
  logic            win_ex;
  logic [PN_W-1:0] off_mask;
  tlb_status_e     status_d;
  logic [IDXW-1:0] idx_d;
  logic [31:0]     paddr_d;
  logic [2:0]      size_d;
  logic [2:0]      rights_d;

  always_comb begin
    win      = ent[pick];
    win_wr   = wr_ok_v[pick];
    win_ex   = ex_ok_v[pick];
    off_mask = pn_offset_mask(win.size);
    status_d = ST_MISS;
    idx_d    = '0;
    paddr_d  = '0;
    size_d   = '0;
    rights_d = '0;
    if (found) begin
      idx_d = pick;
      if (((req_acc == ACC_WRITE) && !win_wr) ||
          ((req_acc == ACC_FETCH) && !win_ex)) begin
        status_d = ST_FAULT;
      end else begin
        status_d = ST_HIT;
        paddr_d  = {(win.rpn & ~off_mask) | (req_vaddr[31:10] & off_mask),
                    req_vaddr[9:0]};
        size_d   = win.size;
        rights_d = {1'b1, win_wr, win_ex};
      end
    end
  end

  // Response registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_status <= ST_MISS;
      rsp_idx    <= '0;
      rsp_paddr  <= '0;
      rsp_size   <= '0;
      rsp_rights <= '0;
    end else if (req_valid) begin
      rsp_status <= status_d;
      rsp_idx    <= idx_d;
      rsp_paddr  <= paddr_d;
      rsp_size   <= size_d;
      rsp_rights <= rights_d;
    end
  end

endmodule

// File: rtl/tlb_zone_lookup_chk.sv
module tlb_zone_lookup_chk
  import tlb_zone_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  req_acc,
  input logic [31:0] req_vaddr,
  input logic        rsp_valid,
  input logic [1:0]  rsp_status,
  input logic [31:0] rsp_paddr,
  input logic [2:0]  rsp_size,
  input logic [2:0]  rsp_rights
);

  p_rsp_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_spurious_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_status_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_status != 2'd3));

  p_read_no_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_acc == ACC_READ) |=> (rsp_status != ST_FAULT));

  p_write_hit_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_acc == ACC_WRITE) |=> (rsp_status != ST_HIT || rsp_rights[1]));

  p_fetch_hit_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_acc == ACC_FETCH) |=> (rsp_status != ST_HIT || rsp_rights[0]));

  p_hit_read_right_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == ST_HIT) |-> rsp_rights[2]);

  p_offset_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_status != ST_HIT || rsp_paddr[9:0] == $past(req_vaddr[9:0])));

  p_miss_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != ST_HIT) |->
      (rsp_paddr == '0 && rsp_size == '0 && rsp_rights == '0));

endmodule

bind tlb_zone_lookup tlb_zone_lookup_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_acc    (req_acc),
  .req_vaddr  (req_vaddr),
  .rsp_valid  (rsp_valid),
  .rsp_status (rsp_status),
  .rsp_paddr  (rsp_paddr),
  .rsp_size   (rsp_size),
  .rsp_rights (rsp_rights)
);

// File: tb/tlb_zone_lookup_tb.sv
`timescale 1ns/1ps
module tlb_zone_lookup_tb;

  localparam int N    = 64;
  localparam int IDXW = 6;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wr_en;
  logic [IDXW-1:0] wr_idx;
  logic [31:6]     wr_tag;
  logic [31:4]     wr_data;
  logic [7:0]      wr_ptag;
  logic            req_valid;
  logic [31:0]     req_vaddr;
  logic [1:0]      req_acc;
  logic            req_user;
  logic [7:0]      cur_pid;
  logic [31:0]     zone_word;
  logic            zone_en;
  logic [3:0]      zone_count;
  logic            rsp_valid;
  logic [1:0]      rsp_status;
  logic [IDXW-1:0] rsp_idx;
  logic [31:0]     rsp_paddr;
  logic [2:0]      rsp_size;
  logic [2:0]      rsp_rights;

  always #2.5 clk = ~clk;

  tlb_zone_lookup #(.N(N)) u_dut (.*);

  typedef struct packed {
    logic [1:0]      st;
    logic [IDXW-1:0] idx;
    logic [31:0]     pa;
    logic [2:0]      sz;
    logic [2:0]      rt;
  } exp_t;

  exp_t  exp_q [$];
  string name_q [$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;

  function automatic logic [31:6] mk_tag(input logic [31:0] vpage, input logic [2:0] s, input logic v);
    return {vpage[31:10], s, v};
  endfunction

  function automatic logic [31:4] mk_data(input logic [31:0] rpage, input logic ex, input logic wr,
                                          input logic [3:0] zone);
    return {rpage[31:10], ex, wr, zone};
  endfunction

  task automatic put_entry(input int idx, input logic [31:6] t, input logic [31:4] d, input logic [7:0] p);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IDXW'(idx); wr_tag = t; wr_data = d; wr_ptag = p;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: issues one lookup and queues its expected response.
  task automatic lookup(input logic [31:0] va, input logic [1:0] acc, input logic user,
                        input logic [1:0] st, input int idx, input logic [31:0] pa,
                        input logic [2:0] sz, input logic [2:0] rt, input string nm);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_user = user;
    e.st = st; e.idx = IDXW'(idx); e.pa = pa; e.sz = sz; e.rt = rt;
    exp_q.push_back(e);
    name_q.push_back(nm);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: compares each response with the head of the queue.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      exp_t  e;
      string nm;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected response: act status %0d exp none", rsp_status);
      end else begin
        e  = exp_q.pop_front();
        nm = name_q.pop_front();
        if (rsp_status !== e.st || rsp_idx !== e.idx || rsp_paddr !== e.pa ||
            rsp_size !== e.sz || rsp_rights !== e.rt) begin
          errors++;
          $display("FAIL %s: act st=%0d idx=%0d pa=%h sz=%0d rt=%b exp st=%0d idx=%0d pa=%h sz=%0d rt=%b",
                   nm, rsp_status, rsp_idx, rsp_paddr, rsp_size, rsp_rights,
                   e.st, e.idx, e.pa, e.sz, e.rt);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [1:0] RD = 2'd0, WR = 2'd1, FE = 2'd2;
  localparam logic [1:0] MISS = 2'd0, FLT = 2'd1, HIT = 2'd2;

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_tag = '0; wr_data = '0; wr_ptag = '0;
    req_valid = 1'b0; req_vaddr = '0; req_acc = '0; req_user = 1'b0;
    cur_pid = 8'h5A; zone_word = 32'h4000_0000; zone_en = 1'b1; zone_count = 4'd15;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset rsp_valid: act %b exp 0", rsp_valid);
    end

    lookup(32'h0000_1234, RD, 1'b1, MISS, 0, 0, 0, 0, "R11 empty table miss");

    // E0: 4K page at 0x1000, global, write only, zone 0
    put_entry(0, mk_tag(32'h0000_1000, 3'd1, 1'b1), mk_data(32'h8000_0000, 1'b0, 1'b1, 4'd0), 8'h00);
    lookup(32'h0000_1234, RD, 1'b1, HIT, 0, 32'h8000_0234, 3'd1, 3'b110, "R2 4K read hit");
    lookup(32'h0000_1234, WR, 1'b1, HIT, 0, 32'h8000_0234, 3'd1, 3'b110, "R9 4K write hit");
    lookup(32'h0000_1ABC, FE, 1'b1, FLT, 0, 0, 0, 0, "R7 fetch without execute");
    lookup(32'h0000_2000, RD, 1'b1, MISS, 0, 0, 0, 0, "R2 outside page miss");

    // E1: 16K page at 0x100000, owner 0x5A, execute only, zone 1
    put_entry(1, mk_tag(32'h0010_0000, 3'd2, 1'b1), mk_data(32'h0020_0000, 1'b1, 1'b0, 4'd1), 8'h5A);
    zone_word = 32'h5000_0000;
    lookup(32'h0010_3ABC, FE, 1'b1, HIT, 1, 32'h0020_3ABC, 3'd2, 3'b101, "R1 16K fetch hit zone code1");
    lookup(32'h0010_3ABC, WR, 1'b1, FLT, 1, 0, 0, 0, "R7 write without write right");
    cur_pid = 8'h5B;
    lookup(32'h0010_0000, RD, 1'b0, MISS, 0, 0, 0, 0, "R3 owner tag mismatch");
    cur_pid = 8'h5A;
    zone_word = 32'h4000_0000;
    lookup(32'h0010_0010, RD, 1'b1, MISS, 0, 0, 0, 0, "R5 code0 hides from user");
    lookup(32'h0010_0010, RD, 1'b0, HIT, 1, 32'h0020_0010, 3'd2, 3'b101, "R5 code0 supervisor own bits");
    zone_word = 32'h6000_0000;
    lookup(32'h0010_0010, WR, 1'b1, FLT, 1, 0, 0, 0, "R5 code2 user keeps bits");
    lookup(32'h0010_0010, WR, 1'b0, HIT, 1, 32'h0020_0010, 3'd2, 3'b111, "R4 zone1 code2 supervisor grant");
    zone_word = 32'h7000_0000;
    lookup(32'h0010_0010, WR, 1'b1, HIT, 1, 32'h0020_0010, 3'd2, 3'b111, "R5 code3 grants user");
    zone_word = 32'h4000_0000; zone_count = 4'd0;
    lookup(32'h0010_0010, RD, 1'b1, HIT, 1, 32'h0020_0010, 3'd2, 3'b101, "R6 zone beyond count");
    lookup(32'h0010_0010, WR, 1'b1, FLT, 1, 0, 0, 0, "R6 zone beyond count write");
    zone_count = 4'd15; zone_en = 1'b0;
    lookup(32'h0010_0010, RD, 1'b1, HIT, 1, 32'h0020_0010, 3'd2, 3'b101, "R6 zones off");
    zone_en = 1'b1;

    // E2/E3 overlap at 1K page 0x400000: E2 zone 2 read only, E3 zone 0 full
    put_entry(2, mk_tag(32'h0040_0000, 3'd0, 1'b1), mk_data(32'h0300_0000, 1'b0, 1'b0, 4'd2), 8'h00);
    put_entry(3, mk_tag(32'h0040_0000, 3'd0, 1'b1), mk_data(32'h0400_0000, 1'b1, 1'b1, 4'd0), 8'h00);
    lookup(32'h0040_0010, WR, 1'b1, HIT, 3, 32'h0400_0010, 3'd0, 3'b111, "R5 user skips hidden entry");
    lookup(32'h0040_0010, WR, 1'b0, FLT, 2, 0, 0, 0, "R8 first match faults");
    lookup(32'h0040_0010, RD, 1'b0, HIT, 2, 32'h0300_0010, 3'd0, 3'b100, "R8 lowest index wins");
    lookup(32'h0040_0410, RD, 1'b0, MISS, 0, 0, 0, 0, "R1 1K page boundary miss");

    // E63: 16M page
    put_entry(63, mk_tag(32'h2300_0000, 3'd7, 1'b1), mk_data(32'h4000_0000, 1'b1, 1'b1, 4'd0), 8'h00);
    lookup(32'h23AB_CDEF, FE, 1'b1, HIT, 63, 32'h40AB_CDEF, 3'd7, 3'b111, "R1 16M hit last index");
    lookup(32'h2400_0000, RD, 1'b1, MISS, 0, 0, 0, 0, "R1 16M next page miss");

    // Invalidate E0
    put_entry(0, mk_tag(32'h0000_1000, 3'd1, 1'b0), mk_data(32'h8000_0000, 1'b0, 1'b1, 4'd0), 8'h00);
    lookup(32'h0000_1234, RD, 1'b1, MISS, 0, 0, 0, 0, "R12 invalidated entry miss");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 missing responses: act %0d pending exp 0", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule